// File: doc/BRIEF.md
# Serial Command and Register Port

This block is a synchronous serial slave that gives an external controller access to eight 24-bit registers inside the chip. The controller pulls the active-low select, shifts in an 8-bit command byte, and then moves exactly 24 data bits. The command byte names one register and the direction. Writes stream their data straight after the command. Reads pause while the block fetches the word over its internal register bus. The block then signals with an active-low ready output that the word has been loaded and can be clocked out.

The serial inputs are synchronised into the system clock domain and edge-detected there. The rest of the chip sees only a parallel register bus. This bus carries a 3-bit address, a 24-bit write word with a one-cycle write strobe, and a one-cycle read request answered by read data with a valid pulse. What the registers hold is outside this block.

Top module: `ser_cmd_port`

## Requirements
- R1: After reset the port is in command mode: `sdo_oe_o` is 0, `rdy_n_o` is 1, and neither `reg_we_o` nor `reg_rreq_o` is asserted.
- R2: A command byte is accepted only when bit 7 is 1 and bits 6:4 are 0. Bits 3:1 give the register address and bit 0 gives the direction (1 = read, 0 = write). Any other byte is ignored and the port stays in command mode, so the next 8 bits form a new command.
- R3: A write command to address 000 (conversion data) is ignored and the port stays in command mode.
- R4: After a valid write command, the next 24 bits sampled on rising serial clock edges form the write word, MSB first, with no gap needed after the command. Exactly one single-cycle `reg_we_o` pulse follows the 24th bit, carrying the command's address and the word.
- R5: A valid read command raises `reg_rreq_o` for one cycle with the command's address. `rdy_n_o` stays 1 until `reg_rvalid_i` answers.
- R6: When `reg_rvalid_i` is seen, the word on `reg_rdata_i` is loaded and `rdy_n_o` goes to 0. While the select is low, `sdo_oe_o` is 1 and `sdo_o` shows bit 23.
- R7: In a read, each falling serial clock edge moves `sdo_o` to the next lower bit. After the 24th falling edge, the port returns to command mode with `rdy_n_o` at 1 and `sdo_o` released.
- R8: Raising the select at any point returns the port to command mode, releases `sdo_o`, sets `rdy_n_o` to 1 and drops any partial transfer without a write strobe. This also ends a read of the conversion data early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csn_i | input | 1 | Serial select, active low |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for `sdo_o` |
| rdy_n_o | output | 1 | Read word ready, active low |
| reg_addr_o | output | 3 | Register address |
| reg_wdata_o | output | 24 | Register write word |
| reg_we_o | output | 1 | Write strobe, one cycle |
| reg_rreq_o | output | 1 | Read request, one cycle |
| reg_rdata_i | input | 24 | Register read word |
| reg_rvalid_i | input | 1 | Read word valid |

## Verification
The assertions check several rules on every cycle. Both strobes last a single cycle and never coincide. A read request only occurs while ready is high. The conversion address never reaches a write strobe. The output driver is enabled only with ready low. A select held high always leaves the output released and ready high. Only the bench scenarios can show the rest: command decoding and rejection, MSB-first assembly of write words, the bit order of read-back data, holding ready off while the register bus stalls, and the port recovering cleanly into command mode after an aborted read or write.

// File: rtl/ser_port_pkg.sv
package ser_port_pkg;

  localparam int CMD_W  = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    ST_CMD  = 2'd0,
    ST_WR   = 2'd1,
    ST_WAIT = 2'd2,
    ST_RD   = 2'd3
  } port_st_t;

  // Accepts top bit set, reserved bits clear, and no write to address 0.
  function automatic logic cmd_ok(input logic [CMD_W-1:0] c);
    return c[7] && (c[6:4] == 3'b000) && !(!c[0] && (c[3:1] == 3'b000));
  endfunction

endpackage

// File: rtl/ser_port_sync.sv
module ser_port_sync #(
  parameter int               W       = 3,
  parameter int               STAGES  = 2,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] q_prev_o
);

  logic [W-1:0] chain [STAGES+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= RST_VAL;
    else        chain[0] <= d_i;
  end

  for (genvar k = 1; k <= STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[k] <= RST_VAL;
      else        chain[k] <= chain[k-1];
    end
  end

  assign q_o      = chain[STAGES-1];
  assign q_prev_o = chain[STAGES];

endmodule

// File: rtl/ser_port_shift.sv
module ser_port_shift #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_in_en,
  input  logic         shift_out_en,
  input  logic         load_en,
  input  logic         bit_i,
  input  logic [W-1:0] load_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q_r, q_n;

  always_comb begin
    q_n = q_r;
    if (load_en)           q_n = load_i;
    else if (shift_in_en)  q_n = {q_r[W-2:0], bit_i};
    else if (shift_out_en) q_n = {q_r[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  q_r <= '0;
    else if (load_en | shift_in_en | shift_out_en) q_r <= q_n;
  end

  assign q_o = q_r;

endmodule

// File: rtl/ser_port_ctrl.sv
module ser_port_ctrl
  import ser_port_pkg::*;
#(
  parameter int DATA_W = 24,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              sdi_bit,
  input  logic [CMD_W-2:0]  cmd_lo,
  input  logic              rvalid,
  output logic              shift_in_en,
  output logic              shift_out_en,
  output logic              load_en,
  output port_st_t          st_o,
  output logic              we_o,
  output logic              rreq_o,
  output logic [ADDR_W-1:0] addr_o
);

  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  port_st_t          st_r, st_n;
  logic [CNT_W-1:0]  cnt_r, cnt_n;
  logic [ADDR_W-1:0] addr_r, addr_n;
  logic              we_r, we_n, rreq_r, rreq_n;
  logic [CMD_W-1:0]  cmd_now;

  assign cmd_now = {cmd_lo, sdi_bit};

  always_comb begin
    st_n         = st_r;
    cnt_n        = cnt_r;
    addr_n       = addr_r;
    we_n         = 1'b0;
    rreq_n       = 1'b0;
    shift_in_en  = 1'b0;
    shift_out_en = 1'b0;
    load_en      = 1'b0;
    if (!cs_act) begin
      st_n  = ST_CMD;
      cnt_n = '0;
    end else begin
      unique case (st_r)
        ST_CMD: if (sclk_rise) begin
          shift_in_en = 1'b1;
          if (cnt_r == CMD_LAST) begin
            cnt_n = '0;
            if (cmd_ok(cmd_now)) begin
              addr_n = cmd_now[3:1];
              if (cmd_now[0]) begin
                st_n   = ST_WAIT;
                rreq_n = 1'b1;
              end else begin
                st_n = ST_WR;
              end
            end
          end else begin
            cnt_n = cnt_r + 1'b1;
          end
        end
        ST_WR: if (sclk_rise) begin
          shift_in_en = 1'b1;
          if (cnt_r == DATA_LAST) begin
            cnt_n = '0;
            we_n  = 1'b1;
            st_n  = ST_CMD;
          end else begin
            cnt_n = cnt_r + 1'b1;
          end
        end
        ST_WAIT: if (rvalid) begin
          load_en = 1'b1;
          cnt_n   = '0;
          st_n    = ST_RD;
        end
        ST_RD: if (sclk_fall) begin
          shift_out_en = 1'b1;
          if (cnt_r == DATA_LAST) begin
            cnt_n = '0;
            st_n  = ST_CMD;
          end else begin
            cnt_n = cnt_r + 1'b1;
          end
        end
        default: st_n = ST_CMD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_r   <= ST_CMD;
      cnt_r  <= '0;
      addr_r <= '0;
      we_r   <= 1'b0;
      rreq_r <= 1'b0;
    end else begin
      st_r   <= st_n;
      cnt_r  <= cnt_n;
      addr_r <= addr_n;
      we_r   <= we_n;
      rreq_r <= rreq_n;
    end
  end

  assign st_o   = st_r;
  assign we_o   = we_r;
  assign rreq_o = rreq_r;
  assign addr_o = addr_r;

endmodule

// File: rtl/ser_cmd_port.sv
module ser_cmd_port
  import ser_port_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              rdy_n_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  output logic              reg_rreq_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  input  logic              reg_rvalid_i
);

  // bit 2: select, bit 1: serial clock, bit 0: data in
  localparam logic [2:0] SYNC_RST = 3'b100;

  logic [2:0]        pin_q, pin_prev;
  logic              cs_act, sclk_rise, sclk_fall;
  logic              sh_in, sh_out, sh_load;
  logic [DATA_W-1:0] sh_q;
  port_st_t          st;

  ser_port_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .d_i      ({csn_i, sclk_i, sdi_i}),
    .q_o      (pin_q),
    .q_prev_o (pin_prev)
  );

  assign cs_act    = ~pin_q[2];
  assign sclk_rise =  pin_q[1] & ~pin_prev[1];
  assign sclk_fall = ~pin_q[1] &  pin_prev[1];

  ser_port_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_act       (cs_act),
    .sclk_rise    (sclk_rise),
    .sclk_fall    (sclk_fall),
    .sdi_bit      (pin_q[0]),
    .cmd_lo       (sh_q[CMD_W-2:0]),
    .rvalid       (reg_rvalid_i),
    .shift_in_en  (sh_in),
    .shift_out_en (sh_out),
    .load_en      (sh_load),
    .st_o         (st),
    .we_o         (reg_we_o),
    .rreq_o       (reg_rreq_o),
    .addr_o       (reg_addr_o)
  );

  ser_port_shift #(.W(DATA_W)) u_shift (
    .clk          (clk),
    .rst_n        (rst_n),
    .shift_in_en  (sh_in),
    .shift_out_en (sh_out),
    .load_en      (sh_load),
    .bit_i        (pin_q[0]),
    .load_i       (reg_rdata_i),
    .q_o          (sh_q)
  );

  assign reg_wdata_o = sh_q;
  assign sdo_o       = sh_q[DATA_W-1];
  assign rdy_n_o     = (st != ST_RD);
  assign sdo_oe_o    = cs_act & (st == ST_RD);

endmodule

// File: rtl/ser_cmd_port_chk.sv
module ser_cmd_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       csn_i,
  input logic       sdo_oe_o,
  input logic       rdy_n_o,
  input logic [2:0] reg_addr_o,
  input logic       reg_we_o,
  input logic       reg_rreq_o
);

  // R1
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_we_o, reg_rreq_o}));

  // R4
  we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |=> !reg_we_o);

  // R3
  no_conv_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |-> (reg_addr_o != 3'b000));

  // R5
  rreq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rreq_o |=> !reg_rreq_o);

  // R5
  rreq_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rreq_o |-> rdy_n_o);

  // R6
  drive_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe_o |-> !rdy_n_o);

  // R8
  deselect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csn_i && $past(csn_i) && $past(csn_i, 2) && $past(csn_i, 3) && $past(csn_i, 4))
      |-> (!sdo_oe_o && rdy_n_o));

endmodule

bind ser_cmd_port ser_cmd_port_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .csn_i      (csn_i),
  .sdo_oe_o   (sdo_oe_o),
  .rdy_n_o    (rdy_n_o),
  .reg_addr_o (reg_addr_o),
  .reg_we_o   (reg_we_o),
  .reg_rreq_o (reg_rreq_o)
);

// File: tb/tb_ser_cmd_port.sv
module tb_ser_cmd_port;

  localparam time CLK_PERIOD = 10ns;
  localparam int  HALF_SCLK  = 4;
  localparam int  NVEC       = 9;

  // {kind(2), cmd(8), data(24)}; kind 0 ignored, 1 write, 2 read
  localparam logic [33:0] VEC [NVEC] = '{
    {2'd1, 8'h82, 24'hA55A3C},
    {2'd1, 8'h84, 24'h123456},
    {2'd1, 8'h8E, 24'hFFFFFF},
    {2'd2, 8'h81, 24'h000000},
    {2'd2, 8'h83, 24'h000000},
    {2'd2, 8'h8D, 24'h000000},
    {2'd0, 8'h02, 24'h000000},
    {2'd0, 8'h80, 24'h000000},
    {2'd0, 8'h92, 24'h000000}
  };

  logic        clk, rst_n, csn, sclk, sdi;
  logic        sdo, sdo_oe, rdy_n, we, rreq, rvalid;
  logic [2:0]  addr;
  logic [23:0] wdata, rdata;

  int n_chk, n_bad;
  int we_cnt, rq_cnt;
  logic [2:0]  we_addr, rq_addr, pend_addr;
  logic [23:0] we_data;
  int          pend;
  logic        hold;

  ser_cmd_port dut (
    .clk(clk), .rst_n(rst_n), .csn_i(csn), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .rdy_n_o(rdy_n),
    .reg_addr_o(addr), .reg_wdata_o(wdata), .reg_we_o(we), .reg_rreq_o(rreq),
    .reg_rdata_i(rdata), .reg_rvalid_i(rvalid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [23:0] model_word(input logic [2:0] a);
    return {a, 5'b10110, a, 13'h0A5C} ^ 24'h5A3C96;
  endfunction

  // Register-bus model: answers a read request after a few cycles unless held
  always @(posedge clk) begin
    rvalid <= 1'b0;
    if (!rst_n) begin
      we_cnt <= 0; rq_cnt <= 0; pend <= 0;
    end else begin
      if (we)   begin we_cnt <= we_cnt + 1; we_addr <= addr; we_data <= wdata; end
      if (rreq) begin rq_cnt <= rq_cnt + 1; rq_addr <= addr; pend_addr <= addr; pend <= 3; end
      else if (pend > 1) pend <= pend - 1;
      else if (pend == 1 && !hold) begin
        pend   <= 0;
        rvalid <= 1'b1;
        rdata  <= model_word(pend_addr);
      end
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic b);
    sdi = b; wclk(HALF_SCLK);
    sclk = 1'b1; wclk(HALF_SCLK);
    sclk = 1'b0;
  endtask

  task automatic send(input logic [31:0] v, input int nb);
    for (int i = nb - 1; i >= 0; i--) sbit(v[i]);
    wclk(HALF_SCLK);
  endtask

  task automatic rd_bits(input int nb, output logic [23:0] v);
    v = '0;
    for (int i = 0; i < nb; i++) begin
      sclk = 1'b1; wclk(HALF_SCLK);
      v = {v[22:0], sdo};
      sclk = 1'b0; wclk(HALF_SCLK);
    end
  endtask

  task automatic sel();   csn = 1'b0; wclk(4); endtask
  task automatic desel(); csn = 1'b1; wclk(6); endtask

  task automatic do_write(input logic [7:0] c, input logic [23:0] d, input string req);
    int w0;
    w0 = we_cnt;
    sel(); send({c, d}, 32); wclk(2);
    chk(we_cnt == w0 + 1, req, we_cnt, w0 + 1);
    chk(we_addr == c[3:1], req, we_addr, c[3:1]);
    chk(we_data == d, req, we_data, d);
    desel();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [23:0] got;
    int w0, r0;
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; csn = 1'b1; sclk = 1'b0; sdi = 1'b0; hold = 1'b0;
    rvalid = 1'b0; rdata = '0;
    wclk(5);
    // R1 reset state
    chk(sdo_oe == 1'b0, "R1", sdo_oe, 0);
    chk(rdy_n == 1'b1, "R1", rdy_n, 1);
    chk(we == 1'b0 && rreq == 1'b0, "R1", {we, rreq}, 0);
    rst_n = 1'b1; wclk(4);
    chk(rdy_n == 1'b1 && sdo_oe == 1'b0, "R1", {rdy_n, sdo_oe}, 2);

    for (int k = 0; k < NVEC; k++) begin
      logic [1:0]  kind;
      logic [7:0]  c;
      logic [23:0] d;
      {kind, c, d} = VEC[k];
      if (kind == 2'd1) begin
        do_write(c, d, "R4");
      end else if (kind == 2'd2) begin
        r0 = rq_cnt;
        sel(); send(c, 8); wclk(8);
        chk(rq_cnt == r0 + 1 && rq_addr == c[3:1], "R5", rq_addr, c[3:1]);
        chk(rdy_n == 1'b0 && sdo_oe == 1'b1, "R6", {rdy_n, sdo_oe}, 2'b01);
        chk(sdo == model_word(c[3:1])[23], "R6", sdo, model_word(c[3:1])[23]);
        rd_bits(24, got); wclk(2);
        chk(got == model_word(c[3:1]), "R7", got, model_word(c[3:1]));
        chk(rdy_n == 1'b1 && sdo_oe == 1'b0, "R7", {rdy_n, sdo_oe}, 2'b10);
        desel();
      end else begin
        w0 = we_cnt; r0 = rq_cnt;
        sel(); send(c, 8); wclk(8);
        chk(we_cnt == w0 && rq_cnt == r0, (c == 8'h80) ? "R3" : "R2", {we_cnt, rq_cnt}, {w0, r0});
        chk(rdy_n == 1'b1, (c == 8'h80) ? "R3" : "R2", rdy_n, 1);
        // still in command mode: a write right behind it must land
        send({8'h84, 24'hC0FFEE}, 32); wclk(2);
        chk(we_cnt == w0 + 1 && we_data == 24'hC0FFEE, "R2", we_data, 24'hC0FFEE);
        desel();
      end
    end

    // R5: ready stays high while the register bus stalls
    hold = 1'b1; r0 = rq_cnt;
    sel(); send(8'h85, 8); wclk(30);
    chk(rq_cnt == r0 + 1 && rdy_n == 1'b1, "R5", rdy_n, 1);
    chk(sdo_oe == 1'b0, "R5", sdo_oe, 0);
    hold = 1'b0; wclk(6);
    chk(rdy_n == 1'b0, "R6", rdy_n, 0);
    rd_bits(24, got); wclk(2);
    chk(got == model_word(3'd2), "R7", got, model_word(3'd2));
    desel();

    // R8: conversion read cut short by deselect
    sel(); send(8'h81, 8); wclk(8);
    rd_bits(8, got);
    chk(got == model_word(3'd0)[23:16], "R8", got, model_word(3'd0)[23:16]);
    desel();
    chk(rdy_n == 1'b1 && sdo_oe == 1'b0, "R8", {rdy_n, sdo_oe}, 2'b10);
    do_write(8'h86, 24'h0F1E2D, "R8");

    // R8: write aborted mid-word leaves no strobe
    w0 = we_cnt;
    sel(); send({8'h88, 10'h3A5}, 18); desel();
    chk(we_cnt == w0, "R8", we_cnt, w0);
    do_write(8'h8A, 24'h800001, "R8");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule